// File: doc/BRIEF.md
# Two-Phase Calibration Trim Sequencer

This block runs a fixed calibration routine for an amplifier channel that has two 4-bit trim codes. The first code sets the gain and the second sets the common-mode rejection. The routine has two phases and the gain phase always comes first. In that phase the stimulus is routed differentially: one input is strapped to the reference and the test tone drives the other. The sequencer tries all sixteen gain codes. For each one it asks an external amplitude-measurement unit for a reading, and it keeps the code whose reading lies nearest a programmed target.

In the second phase both inputs are strapped together, so the tone appears as a common-mode signal. The gain code stays at the value the first phase chose. All sixteen common-mode codes are tried, and the sequencer keeps the code that gives the smallest reading. At the end it pulses `done_o` and raises `pass_o` if both best errors are under their programmed limits. The routine starts by itself when reset is released, and it can be run again with `start_i` once it is idle. A constant output tells the measurement unit how many tone periods each reading must span.

State machine. The states are IDLE, SETTLE, REQUEST, AWAIT and DONE, and reset enters SETTLE with the gain phase and code 0. The transitions are:
- IDLE→SETTLE when `start_i` is high.
- SETTLE→REQUEST when the settle counter reaches `settle_cnt_i`.
- REQUEST→AWAIT unconditionally.
- AWAIT→SETTLE on `meas_valid_i`, with the next code; after gain code 15 this is also where the phase changes to common-mode and the code returns to 0.
- AWAIT→DONE on `meas_valid_i` for common-mode code 15.
- DONE→IDLE unconditionally.

Top module: `trim_cal_sequencer`

## Requirements
- R1: When reset is released the sweep is already running, in the gain phase at code 0. A `start_i` accepted in IDLE restarts the sweep the same way and clears the previous results.
- R2: For each candidate the sequencer holds the code for `settle_cnt_i`+1 cycles. It then drives `meas_req_o` high for exactly one cycle and waits in AWAIT, for any number of cycles, until `meas_valid_i` is seen. A `meas_valid_i` that arrives outside AWAIT is ignored.
- R3: The gain phase presents `gain_code_o` values 0 to 15 in ascending order, with `route_diff_o`=1 and `route_cm_o`=0. `cm_code_o` reads 0 throughout this phase.
- R4: The kept gain code is the one with the smallest |`meas_value_i` − `target_i`|. On a tie the lower code wins.
- R5: The common-mode phase follows immediately and presents `cm_code_o` values 0 to 15 in ascending order, with `route_cm_o`=1 and `route_diff_o`=0. `gain_code_o` holds the code kept by R4 throughout this phase.
- R6: The kept common-mode code is the one with the smallest `meas_value_i`. On a tie the lower code wins.
- R7: `done_o` is a one-cycle pulse in the cycle after the 16th common-mode result is accepted. From that cycle on, both routes are 0 and both code outputs show the kept codes.
- R8: From the DONE cycle until the next start, `pass_o` is 1 exactly when the best gain error is strictly below `gain_limit_i` and the smallest common-mode reading is strictly below `cm_limit_i`. At all other times `pass_o` is 0.
- R9: In IDLE the block issues no request and drives no route. A `start_i` that arrives during a sweep is ignored.
- R10: `meas_periods_o` is the constant measurement window in tone periods, 50 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart request, accepted in IDLE |
| settle_cnt_i | input | 8 | Settling cycles minus one per candidate |
| target_i | input | 16 | Gain-phase target reading |
| gain_limit_i | input | 16 | Pass limit on the best gain error |
| cm_limit_i | input | 16 | Pass limit on the smallest common-mode reading |
| meas_req_o | output | 1 | One-cycle measurement request |
| meas_periods_o | output | 6 | Measurement window in tone periods |
| meas_valid_i | input | 1 | Measurement result strobe |
| meas_value_i | input | 16 | Measured amplitude |
| gain_code_o | output | 4 | Gain trim code |
| cm_code_o | output | 4 | Common-mode trim code |
| route_diff_o | output | 1 | Differential routing: one input to reference |
| route_cm_o | output | 1 | Common-mode routing: both inputs joined |
| done_o | output | 1 | Sequence complete pulse |
| pass_o | output | 1 | Both best errors under their limits |

## Verification
After reset or an accepted start, a candidate's code is visible at once and stays there for `settle_cnt_i`+1 cycles. The request appears in the next cycle. A result driven in an AWAIT cycle advances the code one cycle later, and `done_o` with a valid `pass_o` appears in the cycle after the last result. The bench walks this schedule with a behavioural loop that compares every output in every cycle, sampling on the falling edge after the registers have settled. It varies the result latency per code, injects stray results and stray starts, and computes the expected kept codes and the expected pass value from its own running minima.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_REQUEST = 3'd2,
        ST_AWAIT   = 3'd3,
        ST_DONE    = 3'd4
    } seq_state_e;

    typedef enum logic {
        PH_GAIN = 1'b0,
        PH_CM   = 1'b1
    } trim_phase_e;

endpackage

// File: rtl/trim_best_tracker.sv
module trim_best_tracker #(
    parameter int CODE_W = 4,
    parameter int MET_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] cand_code_i,
    input  logic [MET_W-1:0]  metric_i,
    output logic [CODE_W-1:0] best_code_o,
    output logic [MET_W-1:0]  best_metric_o
);

    logic [CODE_W-1:0] best_code_q;
    logic [MET_W-1:0]  best_metric_q;
    logic              better;

    // Strict compare in an ascending sweep keeps the lower code on a tie.
    always_comb begin
        better = (cand_code_i == '0) || (metric_i < best_metric_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_code_q   <= '0;
            best_metric_q <= '1;
        end else if (clr_i) begin
            best_code_q   <= '0;
            best_metric_q <= '1;
        end else if (upd_i && better) begin
            best_code_q   <= cand_code_i;
            best_metric_q <= metric_i;
        end
    end

    assign best_code_o   = best_code_q;
    assign best_metric_o = best_metric_q;

    // The recorded minimum never grows within one sweep.
    assert_best_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (best_metric_q <= $past(best_metric_q)));

endmodule

// File: rtl/trim_seq_fsm.sv
module trim_seq_fsm
    import trim_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                meas_valid_i,
    input  logic [SETTLE_W-1:0] settle_cnt_i,
    output seq_state_e          state_o,
    output trim_phase_e         phase_o,
    output logic [CODE_W-1:0]   code_o,
    output logic                clr_o,
    output logic                eval_o,
    output logic                finish_o
);

    localparam logic [CODE_W-1:0] LAST_CODE = {CODE_W{1'b1}};

    seq_state_e            state_q, state_d;
    trim_phase_e           phase_q;
    logic [CODE_W-1:0]     code_q;
    logic [SETTLE_W-1:0]   wait_q;
    logic                  settled;
    logic                  last_code;
    logic                  accept;

    always_comb begin
        settled   = (wait_q == settle_cnt_i);
        last_code = (code_q == LAST_CODE);
        accept    = (state_q == ST_AWAIT) && meas_valid_i;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SETTLE;
            ST_SETTLE:  if (settled) state_d = ST_REQUEST;
            ST_REQUEST: state_d = ST_AWAIT;
            ST_AWAIT: begin
                if (meas_valid_i) begin
                    state_d = (last_code && phase_q == PH_CM) ? ST_DONE : ST_SETTLE;
                end
            end
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Sweep position and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_GAIN;
            code_q  <= '0;
            wait_q  <= '0;
        end else begin
            if (state_q == ST_SETTLE && !settled) begin
                wait_q <= wait_q + 1'b1;
            end else begin
                wait_q <= '0;
            end
            if (state_q == ST_IDLE && start_i) begin
                phase_q <= PH_GAIN;
                code_q  <= '0;
            end else if (accept) begin
                if (last_code) begin
                    code_q <= '0;
                    if (phase_q == PH_GAIN) begin
                        phase_q <= PH_CM;
                    end
                end else begin
                    code_q <= code_q + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        state_o  = state_q;
        phase_o  = phase_q;
        code_o   = code_q;
        clr_o    = (state_q == ST_IDLE) && start_i;
        eval_o   = accept;
        finish_o = accept && last_code && (phase_q == PH_CM);
    end

    assert_req_then_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQUEST) |=> (state_q == ST_AWAIT));

    assert_settle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && state_d == ST_SETTLE) |=> ($stable(code_q) && $stable(phase_q)));

    assert_restart_gain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> (state_q == ST_SETTLE && phase_q == PH_GAIN && code_q == '0));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQUEST && start_i) |=> (state_q == ST_AWAIT));

endmodule

// File: rtl/trim_cal_sequencer.sv
module trim_cal_sequencer
    import trim_pkg::*;
#(
    parameter int CODE_W       = 4,
    parameter int MET_W        = 16,
    parameter int SETTLE_W     = 8,
    parameter int MEAS_PERIODS = 50,
    localparam int PER_W       = $clog2(MEAS_PERIODS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_cnt_i,
    input  logic [MET_W-1:0]    target_i,
    input  logic [MET_W-1:0]    gain_limit_i,
    input  logic [MET_W-1:0]    cm_limit_i,
    output logic                meas_req_o,
    output logic [PER_W-1:0]    meas_periods_o,
    input  logic                meas_valid_i,
    input  logic [MET_W-1:0]    meas_value_i,
    output logic [CODE_W-1:0]   gain_code_o,
    output logic [CODE_W-1:0]   cm_code_o,
    output logic                route_diff_o,
    output logic                route_cm_o,
    output logic                done_o,
    output logic                pass_o
);

    seq_state_e        state;
    trim_phase_e       phase;
    logic [CODE_W-1:0] sweep_code;
    logic              clr, eval, finish;
    logic              active;
    logic [MET_W-1:0]  gain_err;
    logic [CODE_W-1:0] gain_best_code, cm_best_code;
    logic [MET_W-1:0]  gain_best_err,  cm_best_val;
    logic              result_q;

    trim_seq_fsm #(
        .CODE_W   (CODE_W),
        .SETTLE_W (SETTLE_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .meas_valid_i (meas_valid_i),
        .settle_cnt_i (settle_cnt_i),
        .state_o      (state),
        .phase_o      (phase),
        .code_o       (sweep_code),
        .clr_o        (clr),
        .eval_o       (eval),
        .finish_o     (finish)
    );

    always_comb begin
        gain_err = (meas_value_i >= target_i) ? (meas_value_i - target_i)
                                              : (target_i - meas_value_i);
    end

    trim_best_tracker #(
        .CODE_W (CODE_W),
        .MET_W  (MET_W)
    ) u_gain_best (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (clr),
        .upd_i         (eval && phase == PH_GAIN),
        .cand_code_i   (sweep_code),
        .metric_i      (gain_err),
        .best_code_o   (gain_best_code),
        .best_metric_o (gain_best_err)
    );

    trim_best_tracker #(
        .CODE_W (CODE_W),
        .MET_W  (MET_W)
    ) u_cm_best (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (clr),
        .upd_i         (eval && phase == PH_CM),
        .cand_code_i   (sweep_code),
        .metric_i      (meas_value_i),
        .best_code_o   (cm_best_code),
        .best_metric_o (cm_best_val)
    );

    // Result-valid flag: set by the last common-mode result, cleared on restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= 1'b0;
        end else if (clr) begin
            result_q <= 1'b0;
        end else if (finish) begin
            result_q <= 1'b1;
        end
    end

    always_comb begin
        active         = (state == ST_SETTLE) || (state == ST_REQUEST) || (state == ST_AWAIT);
        route_diff_o   = active && (phase == PH_GAIN);
        route_cm_o     = active && (phase == PH_CM);
        gain_code_o    = route_diff_o ? sweep_code : gain_best_code;
        cm_code_o      = route_cm_o   ? sweep_code : cm_best_code;
        meas_req_o     = (state == ST_REQUEST);
        done_o         = (state == ST_DONE);
        meas_periods_o = PER_W'(MEAS_PERIODS);
        pass_o         = result_q && (gain_best_err < gain_limit_i) && (cm_best_val < cm_limit_i);
    end

    assert_route_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_diff_o && route_cm_o));

    assert_gain_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (route_cm_o && $past(route_cm_o)) |-> $stable(gain_code_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_req_routed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |-> (route_diff_o || route_cm_o));

endmodule

// File: tb/trim_cal_sequencer_bench.sv
module trim_cal_sequencer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [7:0]  settle_cnt_i;
    logic [15:0] target_i, gain_limit_i, cm_limit_i;
    logic        meas_req_o;
    logic [5:0]  meas_periods_o;
    logic        meas_valid_i;
    logic [15:0] meas_value_i;
    logic [3:0]  gain_code_o, cm_code_o;
    logic        route_diff_o, route_cm_o, done_o, pass_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_cal_sequencer u_trim_cal_sequencer (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .settle_cnt_i   (settle_cnt_i),
        .target_i       (target_i),
        .gain_limit_i   (gain_limit_i),
        .cm_limit_i     (cm_limit_i),
        .meas_req_o     (meas_req_o),
        .meas_periods_o (meas_periods_o),
        .meas_valid_i   (meas_valid_i),
        .meas_value_i   (meas_value_i),
        .gain_code_o    (gain_code_o),
        .cm_code_o      (cm_code_o),
        .route_diff_o   (route_diff_o),
        .route_cm_o     (route_cm_o),
        .done_o         (done_o),
        .pass_o         (pass_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic int meas_val(input int scen, input bit cm, input int code);
        case (scen)
            0:       return cm ? (code - 11) * (code - 11) * 3 + 4 : 1000 + 37 * code;
            1:       return cm ? ((code == 4 || code == 12) ? 2 : 50 + code) : 500 + 10 * code;
            default: return cm ? 100 - code : 2000 - 3 * code;
        endcase
    endfunction

    // Compare every output of one sweep cycle.
    task automatic sweep_cycle(input bit cm, input int g, input int c, input bit req);
        chk(cm ? "R5 gain code" : "R3 gain code", gain_code_o, g);
        chk(cm ? "R5 cm code"   : "R3 cm code",   cm_code_o,   c);
        chk(cm ? "R5 route diff" : "R3 route diff", route_diff_o, !cm);
        chk(cm ? "R5 route cm"   : "R3 route cm",   route_cm_o,   cm);
        chk("R2 request", meas_req_o, req);
        chk("R7 done low", done_o, 1'b0);
        chk("R8 pass low in sweep", pass_o, 1'b0);
    endtask

    task automatic run_sweep(input int scen, input int settle, input int target,
                             input int glim, input int clim, input bit poke_start);
        int bg_code = 0, bg_err = 0, bc_code = 0, bc_val = 0;
        for (int ph = 0; ph < 2; ph++) begin
            for (int code = 0; code < 16; code++) begin
                int eg, ec, lat, v;
                eg  = (ph == 1) ? bg_code : code;
                ec  = (ph == 1) ? code : 0;
                lat = (scen == 2) ? 0 : code % 3;
                for (int s = 0; s <= settle; s++) begin
                    sweep_cycle(ph == 1, eg, ec, 1'b0);
                    if (s == 0 && code == 2) begin
                        meas_valid_i = 1'b1;     // stray result in SETTLE (R2)
                        meas_value_i = 16'd0;
                    end
                    if (poke_start && s == 0 && code == 3) start_i = 1'b1; // R9
                    @(negedge clk);
                    meas_valid_i = 1'b0;
                    start_i      = 1'b0;
                end
                sweep_cycle(ph == 1, eg, ec, 1'b1);
                @(negedge clk);
                for (int w = 0; w < lat; w++) begin
                    sweep_cycle(ph == 1, eg, ec, 1'b0);
                    @(negedge clk);
                end
                sweep_cycle(ph == 1, eg, ec, 1'b0);
                v = meas_val(scen, ph == 1, code);
                meas_valid_i = 1'b1;
                meas_value_i = 16'(v);
                @(negedge clk);
                meas_valid_i = 1'b0;
                if (ph == 0) begin
                    int e;
                    e = (v >= target) ? v - target : target - v;
                    if (code == 0 || e < bg_err) begin bg_err = e; bg_code = code; end
                end else begin
                    if (code == 0 || v < bc_val) begin bc_val = v; bc_code = code; end
                end
            end
        end
        // DONE cycle
        chk("R7 done pulse", done_o, 1'b1);
        chk("R4 kept gain code", gain_code_o, bg_code);
        chk("R6 kept cm code", cm_code_o, bc_code);
        chk("R7 routes released", {route_diff_o, route_cm_o}, 2'b00);
        chk("R8 pass verdict", pass_o, (bg_err < glim) && (bc_val < clim));
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R7 done one cycle", done_o, 1'b0);
            chk("R8 pass held", pass_o, (bg_err < glim) && (bc_val < clim));
            chk("R7 codes held", {gain_code_o, cm_code_o}, {4'(bg_code), 4'(bc_code)});
            chk("R9 idle quiet", {meas_req_o, route_diff_o, route_cm_o}, 3'b000);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL R7 watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        start_i      = 1'b0;
        meas_valid_i = 1'b0;
        meas_value_i = '0;
        settle_cnt_i = 8'd2;
        target_i     = 16'd1250;
        gain_limit_i = 16'd10;
        cm_limit_i   = 16'd5;
        repeat (3) @(negedge clk);
        chk("R1 reset route diff", route_diff_o, 1'b1);
        chk("R1 reset codes", {gain_code_o, cm_code_o}, 8'h00);
        chk("R1 reset no request", meas_req_o, 1'b0);
        chk("R8 reset pass", pass_o, 1'b0);
        chk("R10 window", meas_periods_o, 50);
        rst_n = 1'b1;
        // Scenario A: automatic start, stray start mid-sweep, pass expected.
        run_sweep(0, 2, 1250, 10, 5, 1'b1);

        // Scenario B: ties in both phases, gain error equals its limit.
        settle_cnt_i = 8'd1;
        target_i     = 16'd575;
        gain_limit_i = 16'd5;
        cm_limit_i   = 16'd3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        run_sweep(1, 1, 575, 5, 3, 1'b0);

        // Scenario C: no settle, zero latency, all readings below target.
        settle_cnt_i = 8'd0;
        target_i     = 16'd3000;
        gain_limit_i = 16'd2000;
        cm_limit_i   = 16'd90;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        run_sweep(2, 0, 3000, 2000, 90, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule